// File: doc/BRIEF.md
# Cascaded PIC Vector Readout Encoder

This block is a read-only register that tells software which legacy interrupt line is pending, so a handler can fetch a vector in one bus read instead of running the port-based acknowledge handshake with two cascaded 8-line interrupt controllers. It watches the request and mask registers of a primary controller (lines 0 to 7) and a secondary controller (lines 8 to 15). Line 2 is never reported, because it carries the cascade from the secondary controller.

A line is a candidate when its request bit is set and its mask bit is clear. The lowest-numbered candidate wins. A read strobe registers the vector byte, 0x20 plus the winning line number, onto the read-data bus, and the byte stays there until the next read. If no line is a candidate, the read returns 0x20 and sets a sticky spurious flag. A write to the register changes nothing and raises a one-cycle write-error pulse.

Top module: `pic_vector_readout`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_data is 0x00 and rd_valid, spurious and wr_err are all 0.
- R2: A line is a candidate only when its request bit is 1 and its mask bit is 0. A requested but masked line is never reported.
- R3: Line 2 (primary bit 2) is never reported, whatever its request and mask bits are. The search continues past it to line 3 and then to the secondary lines.
- R4: When several lines are candidates, the lowest-numbered one is reported. Primary bits 0..7 are lines 0..7 and secondary bits 0..7 are lines 8..15.
- R5: The clock edge that samples rd_en high loads rd_data with 0x20 plus the 4-bit winning line number (0x20..0x2F), and rd_valid is 1 for exactly that one cycle.
- R6: A read with no candidate loads rd_data with 0x20 and sets spurious at the same edge. A read that finds a candidate never sets spurious.
- R7: Once set, spurious stays 1 through later reads that do find a candidate, and only reset clears it.
- R8: A write strobe (wr_en high, rd_en low) leaves rd_data, rd_valid and spurious unchanged, and wr_err is 1 for exactly the cycle after the strobe.
- R9: Between reads, rd_data holds the last value read, even when the request and mask inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pri | input | 8 | Primary controller request bits, lines 0..7 |
| mask_pri | input | 8 | Primary controller mask bits (1 = masked) |
| req_sec | input | 8 | Secondary controller request bits, lines 8..15 |
| mask_sec | input | 8 | Secondary controller mask bits (1 = masked) |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, ignored apart from the error pulse |
| rd_data | output | 8 | Registered vector byte |
| rd_valid | output | 1 | One-cycle pulse marking fresh rd_data |
| spurious | output | 1 | Sticky flag: a read found no candidate |
| wr_err | output | 1 | One-cycle pulse after a write strobe |

## Verification
Every output is a register, so a wrong internal decision shows at the ports one cycle after the strobe that caused it. A bad qualify or cascade-skip term shows as a wrong low nibble of rd_data, and a broken primary-over-secondary selection shows as a vector from the 0x28..0x2F range when a primary line should have won. A spurious flag that fails to stick or fails to set is visible at the very next read, and a write that leaks into the data path shows as a change in the held rd_data.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int unsigned PVR_CTRL_LINES   = 8;
  localparam int unsigned PVR_CASCADE_LINE = 2;
  localparam int unsigned PVR_DATA_W       = 8;
  localparam logic [7:0]  PVR_VEC_BASE     = 8'h20;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BOTH  = 2'd3
  } pvr_access_e;
endpackage

// File: rtl/pvr_qualify.sv
module pvr_qualify #(
  parameter int unsigned LINES        = 8,
  parameter bit          SKIP_EN      = 1'b0,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] mask,
  output logic [LINES-1:0] pend
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (SKIP_EN && (i == CASCADE_LINE)) begin : g_skip
      assign pend[i] = 1'b0;
    end else begin : g_pass
      assign pend[i] = req[i] & ~mask[i];
    end
  end
endmodule

// File: rtl/pvr_prio_enc.sv
module pvr_prio_enc #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest set bit is the last one assigned.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pvr_read_port.sv
module pvr_read_port
  import pvr_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       IDX_W    = 4,
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              found,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              spurious,
  output logic              wr_err
);
  pvr_access_e       acc;
  logic [DATA_W-1:0] vec_next;
  logic              do_read;

  assign acc = pvr_access_e'({wr_en, rd_en});

  always_comb begin
    vec_next = found ? (VEC_BASE + DATA_W'(idx)) : VEC_BASE;
    case (acc)
      ACC_READ, ACC_BOTH: do_read = 1'b1;
      default:            do_read = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      spurious <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= do_read;
      wr_err   <= (acc == ACC_WRITE) || (acc == ACC_BOTH);
      if (do_read) begin
        rd_data <= vec_next;
        if (!found) spurious <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_vector_readout.sv
module pic_vector_readout
  import pvr_pkg::*;
#(
  parameter int unsigned                 CTRL_LINES   = PVR_CTRL_LINES,
  parameter int unsigned                 CASCADE_LINE = PVR_CASCADE_LINE,
  parameter int unsigned                 DATA_W       = PVR_DATA_W,
  parameter logic [PVR_DATA_W-1:0]       VEC_BASE     = PVR_VEC_BASE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CTRL_LINES-1:0] req_pri,
  input  logic [CTRL_LINES-1:0] mask_pri,
  input  logic [CTRL_LINES-1:0] req_sec,
  input  logic [CTRL_LINES-1:0] mask_sec,
  input  logic                  rd_en,
  input  logic                  wr_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  spurious,
  output logic                  wr_err
);
  localparam int unsigned NUM_CTRL = 2;
  localparam int unsigned CTRL_IW  = (CTRL_LINES > 1) ? $clog2(CTRL_LINES) : 1;
  localparam int unsigned IDX_W    = CTRL_IW + 1;

  logic [NUM_CTRL-1:0][CTRL_LINES-1:0] req_a, mask_a, pend_a;
  logic [NUM_CTRL-1:0]                 found_a;
  logic [NUM_CTRL-1:0][CTRL_IW-1:0]    idx_a;
  logic                                found;
  logic [IDX_W-1:0]                    idx;

  assign req_a  = {req_sec, req_pri};
  assign mask_a = {mask_sec, mask_pri};

  // Controller 0 is the primary and owns the cascade input.
  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    pvr_qualify #(
      .LINES       (CTRL_LINES),
      .SKIP_EN     (c == 0),
      .CASCADE_LINE(CASCADE_LINE)
    ) u_qual (
      .req (req_a[c]),
      .mask(mask_a[c]),
      .pend(pend_a[c])
    );

    pvr_prio_enc #(
      .WIDTH(CTRL_LINES)
    ) u_enc (
      .vec  (pend_a[c]),
      .found(found_a[c]),
      .idx  (idx_a[c])
    );
  end

  // Any primary candidate outranks every secondary line.
  assign found = |found_a;
  assign idx   = found_a[0] ? {1'b0, idx_a[0]} : {1'b1, idx_a[1]};

  pvr_read_port #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .VEC_BASE(DATA_W'(VEC_BASE))
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .found   (found),
    .idx     (idx),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .spurious(spurious),
    .wr_err  (wr_err)
  );
endmodule

// File: rtl/pvr_checker.sv
module pvr_checker #(
  parameter int unsigned       LINES        = 8,
  parameter int unsigned       CASCADE_LINE = 2,
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] VEC_BASE     = 8'h20
) (
  input logic              clk,
  input logic              rst,
  input logic [LINES-1:0]  req_pri,
  input logic [LINES-1:0]  mask_pri,
  input logic [LINES-1:0]  req_sec,
  input logic [LINES-1:0]  mask_sec,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              spurious,
  input logic              wr_err
);
  logic [LINES-1:0] keep_pri;
  logic             any_cand;

  assign keep_pri = ~(LINES'(1) << CASCADE_LINE);
  assign any_cand = |((req_pri & ~mask_pri & keep_pri) | (req_sec & ~mask_sec));

  // R5: rd_valid is a pulse marking the cycle after each read strobe.
  p_valid_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_valid_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R5: a fresh vector lies within base..base+15.
  p_vector_range_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data >= VEC_BASE) && (rd_data <= VEC_BASE + DATA_W'(15)));
  // R3: the cascade line's vector never appears.
  p_no_cascade_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data != (VEC_BASE + DATA_W'(CASCADE_LINE)));
  // R6: a read without candidates yields the base vector and sets the flag.
  p_spurious_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !any_cand) |=> (rd_data == VEC_BASE) && spurious);
  // R7: the spurious flag is sticky.
  p_spurious_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    spurious |=> spurious);
  // R8: the write error is a one-cycle pulse after a write strobe.
  p_wr_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wr_err);
  p_wr_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_err);
  // R9, R8: without a read strobe the data bus holds.
  p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind pic_vector_readout pvr_checker #(
  .LINES       (CTRL_LINES),
  .CASCADE_LINE(CASCADE_LINE),
  .DATA_W      (DATA_W),
  .VEC_BASE    (DATA_W'(VEC_BASE))
) u_pvr_checker (
  .clk     (clk),
  .rst     (rst),
  .req_pri (req_pri),
  .mask_pri(mask_pri),
  .req_sec (req_sec),
  .mask_sec(mask_sec),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .rd_data (rd_data),
  .rd_valid(rd_valid),
  .spurious(spurious),
  .wr_err  (wr_err)
);

// File: tb/test_pic_vector_readout.sv
module test_pic_vector_readout;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_pri = '0, mask_pri = '0, req_sec = '0, mask_sec = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, spurious, wr_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pic_vector_readout i_pic_vector_readout (
    .clk(clk), .rst(rst),
    .req_pri(req_pri), .mask_pri(mask_pri),
    .req_sec(req_sec), .mask_sec(mask_sec),
    .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .spurious(spurious), .wr_err(wr_err)
  );

  // {req_pri, mask_pri, req_sec, mask_sec, expected vector, requirement}
  localparam int NV = 13;
  localparam logic [47:0] VECS [NV] = '{
    {8'h01, 8'h00, 8'h00, 8'h00, 8'h20, 8'd2},
    {8'h80, 8'h00, 8'h00, 8'h00, 8'h27, 8'd4},
    {8'h00, 8'h00, 8'h01, 8'h00, 8'h28, 8'd4},
    {8'h00, 8'h00, 8'h80, 8'h00, 8'h2F, 8'd4},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h20, 8'd4},
    {8'hFF, 8'h01, 8'h00, 8'h00, 8'h21, 8'd2},
    {8'h04, 8'h00, 8'h10, 8'h00, 8'h2C, 8'd3},
    {8'h0C, 8'h00, 8'h00, 8'h00, 8'h23, 8'd3},
    {8'h04, 8'h00, 8'h02, 8'h00, 8'h29, 8'd3},
    {8'hF0, 8'hF0, 8'h30, 8'h10, 8'h2D, 8'd2},
    {8'hA0, 8'h20, 8'h00, 8'h00, 8'h27, 8'd2},
    {8'h00, 8'hFF, 8'h40, 8'h00, 8'h2E, 8'd4},
    {8'h06, 8'h02, 8'hC0, 8'h40, 8'h2F, 8'd3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rd_en = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 8'h00);
    check("R1 flags in reset", {5'd0, rd_valid, spurious, wr_err}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags after reset", {5'd0, rd_valid, spurious, wr_err}, 8'h00);
  endtask

  task automatic set_in(input logic [7:0] rp, mp, rs, ms);
    req_pri = rp; mask_pri = mp; req_sec = rs; mask_sec = ms;
  endtask

  // Strobe one read at a negedge; result is registered at the next posedge.
  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    do_reset();

    // Table walk: R2, R3, R4, R5 with no spurious flagging (R6).
    for (int i = 0; i < NV; i++) begin
      set_in(VECS[i][47:40], VECS[i][39:32], VECS[i][31:24], VECS[i][23:16]);
      do_read();
      check($sformatf("R%0d R5 vector row %0d", VECS[i][7:0], i), rd_data, VECS[i][15:8]);
      check($sformatf("R5 rd_valid row %0d", i), {7'd0, rd_valid}, 8'h01);
      check($sformatf("R6 no spurious row %0d", i), {7'd0, spurious}, 8'h00);
    end

    // R5: rd_valid drops the cycle after.
    @(negedge clk);
    check("R5 rd_valid pulse ends", {7'd0, rd_valid}, 8'h00);

    // R9: inputs change without a read; data holds.
    set_in(8'h02, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 hold rd_data", rd_data, 8'h2F);

    // R8: write ignored, wr_err pulse for one cycle.
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 wr_err pulse", {7'd0, wr_err}, 8'h01);
    check("R8 rd_data unchanged", rd_data, 8'h2F);
    check("R8 no rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R8 no spurious", {7'd0, spurious}, 8'h00);
    @(negedge clk);
    check("R8 wr_err cleared", {7'd0, wr_err}, 8'h00);

    // R6: only the cascade line and masked lines pending.
    set_in(8'h06, 8'h02, 8'hFF, 8'hFF);
    do_read();
    check("R6 spurious vector", rd_data, 8'h20);
    check("R6 spurious set", {7'd0, spurious}, 8'h01);

    // R7: sticky through a good read.
    set_in(8'h20, 8'h00, 8'h00, 8'h00);
    do_read();
    check("R7 good read after spurious", rd_data, 8'h25);
    check("R7 spurious sticky", {7'd0, spurious}, 8'h01);
    repeat (2) @(negedge clk);
    check("R7 spurious still set", {7'd0, spurious}, 8'h01);

    // R7, R1: reset clears the flag; then all-zero inputs are spurious (R6).
    do_reset();
    check("R7 spurious cleared by reset", {7'd0, spurious}, 8'h00);
    set_in(8'h00, 8'h00, 8'h00, 8'h00);
    do_read();
    check("R6 empty inputs vector", rd_data, 8'h20);
    check("R6 empty inputs flag", {7'd0, spurious}, 8'h01);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule